// File: doc/BRIEF.md
# Video Decoder Control Register Bank

This block holds the byte-wide control and status registers of a composite video decoder. A host writes through an active-low chip-select and write-strobe pair. The bank samples the strobe into the register clock domain, turns it into a single internal write pulse, and commits the addressed byte one clock later. Reads need no handshake. The read-data bus follows the address and register contents combinationally, so the host can read at any time.

From the stored bytes the bank produces registered decoded controls for the decoder datapath:
- the resolved colour-standard code;
- the comb-filter mode;
- the black-level, demodulator, rate-converter and oscillator-output selections;
- one effective byte for each timing/gain register.

While the automatic-timing bit is set, each effective timing/gain byte is replaced by a built-in default that depends on the line count of the resolved standard. The programmed values still read back unchanged. A detected line-standard input is brought out for readback through a read-only status byte.

Top module: `vdec_ctl_regbank`

## Requirements
- R1: Synchronous active-low reset loads these values. Address 0x00 reads 0xA0. Address 0x01 reads 0x04. Address 0x02 reads 0x24. Timing/gain address 0x10+k (k = 0..TG_COUNT-1) reads 0x40+k.
- R2: A write is requested when cs_n and wr_n are both low. If the first rising edge that sees the request is edge N, the new value is readable after edge N+3 and not before. The request must be held through edge N+3, and the byte on wdata at edge N+3 is stored.
- R3: One request produces exactly one write, however long it is held. Changing wdata after edge N+3 of a held request does not alter the stored byte.
- R4: With only one of cs_n and wr_n low, nothing is written.
- R5: rdata depends only on addr and the register contents, not on cs_n or wr_n. The following read as 0 and ignore writes: bit 6 of 0x00, bits 6, 4 and 3 of 0x01, bits 7:6 of 0x02, and every address not listed in R1 or R6.
- R6: Address 0x20 reads {6'b0, line625_in, 1'b0}. Address 0x21 reads the VERSION parameter (default 0x07). Writes to either address have no effect.
- R7: std_code reflects register 0x00 one clock after it changes. If bit 5 is 0, std_code equals bits 4:0. If bit 5 is 1, std_code is chosen by line625_in and bit 1:
  - 525 lines, bit 1 = 0: 00000
  - 525 lines, bit 1 = 1: 00010
  - 625 lines, bit 1 = 0: 00100
  - 625 lines, bit 1 = 1: 00110
- R8: Register 0x01 bits 2:0 decode to comb_mode as follows: 000 gives 0 (notch), 001 gives 1 (line), 010 gives 2 (frame), 011 gives 0, and 1xx gives 3 (automatic). Bit 5 drives frame_comb_off and bit 7 drives comb_view.
- R9: Register 0x02 drives these outputs: bit 5 to blk_auto_en, bit 4 to vbi_demod_en, bit 3 to demod_bypass, bit 2 to src_bypass, and bits 1:0 to osc_ctl_sel. tg_auto follows bit 7 of 0x00.
- R10: When bit 7 of 0x00 is 1, eff_tg byte k is 0x40+k if std_code bit 2 is 0, and 0x80+k if it is 1. When bit 7 is 0, byte k equals the programmed register 0x10+k. Readback always returns the programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Register address for read and write |
| wdata | input | 8 | Write data |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| line625_in | input | 1 | Detected line standard, 1 = 625 lines |
| rdata | output | 8 | Combinational read data |
| tg_auto | output | 1 | Built-in timing/gain defaults in force |
| std_code | output | 5 | Resolved colour-standard code |
| comb_mode | output | 2 | 0 notch, 1 line, 2 frame, 3 automatic |
| frame_comb_off | output | 1 | Frame comb disabled |
| comb_view | output | 1 | Comb-mode display enabled |
| blk_auto_en | output | 1 | Automatic black level enabled |
| vbi_demod_en | output | 1 | Demodulate during vertical blanking |
| demod_bypass | output | 1 | Demodulator bypassed |
| src_bypass | output | 1 | Sample-rate converter bypassed |
| osc_ctl_sel | output | 2 | Oscillator output: 0 loop error, 1 low, 2 high, 3 half duty |
| eff_tg | output | 8*TG_COUNT | Effective timing/gain bytes, byte k at bits 8k+7:8k |

## Verification
Directed strobe patterns hold the request and then check it. One pattern holds a request for exactly four edges and samples the readback before and after edge N+3, which separates a correct pipeline from one a stage short or long. A request held far longer with wdata changed mid-way shows whether the edge detector allows only one commit. Strobes with only one of the two enables low show whether the write qualification is complete. Seeded random writes over the low 48 addresses, mixed with line-standard flips, test the masks, the read-only and unused addresses, and the auto-standard and auto-timing selection against a bench model of every byte.

// File: rtl/vdec_ctl_pkg.sv
package vdec_ctl_pkg;

  localparam int ADR_W = 8;
  localparam int REG_W = 8;

  localparam logic [ADR_W-1:0] A_CTRL0 = 8'h00;
  localparam logic [ADR_W-1:0] A_CTRL1 = 8'h01;
  localparam logic [ADR_W-1:0] A_CTRL2 = 8'h02;
  localparam logic [ADR_W-1:0] A_STAT  = 8'h20;
  localparam logic [ADR_W-1:0] A_VER   = 8'h21;
  localparam logic [ADR_W-1:0] TG_BASE = 8'h10;

  localparam logic [REG_W-1:0] M_CTRL0 = 8'hBF;
  localparam logic [REG_W-1:0] M_CTRL1 = 8'hA7;
  localparam logic [REG_W-1:0] M_CTRL2 = 8'h3F;

  localparam logic [REG_W-1:0] D_CTRL0 = 8'hA0;
  localparam logic [REG_W-1:0] D_CTRL1 = 8'h04;
  localparam logic [REG_W-1:0] D_CTRL2 = 8'h24;

  localparam logic [REG_W-1:0] TG_DEF_525 = 8'h40;
  localparam logic [REG_W-1:0] TG_DEF_625 = 8'h80;

  localparam logic [4:0] STD_NTSC  = 5'b00000;
  localparam logic [4:0] STD_PAL_M = 5'b00010;
  localparam logic [4:0] STD_PAL   = 5'b00100;
  localparam logic [4:0] STD_PAL_N = 5'b00110;

  typedef enum logic [1:0] {
    CM_NOTCH = 2'd0,
    CM_LINE  = 2'd1,
    CM_FRAME = 2'd2,
    CM_AUTO  = 2'd3
  } comb_mode_e;

  // Standard chosen from control byte 0 and the detected line count
  function automatic logic [4:0] resolve_std(input logic [REG_W-1:0] c0,
                                             input logic l625);
    logic [4:0] s;
    if (!c0[5])      s = c0[4:0];
    else if (l625)   s = c0[1] ? STD_PAL_N : STD_PAL;
    else             s = c0[1] ? STD_PAL_M : STD_NTSC;
    return s;
  endfunction

  function automatic comb_mode_e decode_comb(input logic [2:0] f);
    comb_mode_e m;
    if (f[2])              m = CM_AUTO;
    else if (f[1:0] == 2'b01) m = CM_LINE;
    else if (f[1:0] == 2'b10) m = CM_FRAME;
    else                   m = CM_NOTCH;
    return m;
  endfunction

endpackage

// File: rtl/vdec_ctl_wr_sync.sv
module vdec_ctl_wr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic we_o
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic            we_q;
  logic            req;

  assign req = ~cs_n & ~wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
      we_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[SH_W-2:0], req};
      we_q <= sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    end
  end

  assign we_o = we_q;

  // R3
  wr_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

endmodule

// File: rtl/vdec_ctl_store.sv
module vdec_ctl_store
  import vdec_ctl_pkg::*;
#(
  parameter int              TG_COUNT = 16,
  parameter logic [REG_W-1:0] VERSION = 8'h07
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ADR_W-1:0]          addr_i,
  input  logic [REG_W-1:0]          wdata_i,
  input  logic                      line625_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic [REG_W-1:0]          ctrl0_o,
  output logic [REG_W-1:0]          ctrl1_o,
  output logic [REG_W-1:0]          ctrl2_o,
  output logic [TG_COUNT*REG_W-1:0] tg_o
);

  localparam int TG_W = TG_COUNT * REG_W;

  logic [REG_W-1:0] ctrl0_q, ctrl1_q, ctrl2_q;
  logic [REG_W-1:0] tg_q [TG_COUNT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl0_q <= D_CTRL0;
      ctrl1_q <= D_CTRL1;
      ctrl2_q <= D_CTRL2;
    end else if (we_i) begin
      if (addr_i == A_CTRL0) ctrl0_q <= wdata_i & M_CTRL0;
      if (addr_i == A_CTRL1) ctrl1_q <= wdata_i & M_CTRL1;
      if (addr_i == A_CTRL2) ctrl2_q <= wdata_i & M_CTRL2;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < TG_COUNT; k++) begin
      if (!rst_n)
        tg_q[k] <= TG_DEF_525 + REG_W'(k);
      else if (we_i && addr_i == ADR_W'(int'(TG_BASE) + k))
        tg_q[k] <= wdata_i;
    end
  end

  // Read path: address and contents only
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL0: rdata_o = ctrl0_q;
      A_CTRL1: rdata_o = ctrl1_q;
      A_CTRL2: rdata_o = ctrl2_q;
      A_STAT:  rdata_o = {6'b0, line625_i, 1'b0};
      A_VER:   rdata_o = VERSION;
      default: rdata_o = '0;
    endcase
    for (int k = 0; k < TG_COUNT; k++)
      if (addr_i == ADR_W'(int'(TG_BASE) + k)) rdata_o = tg_q[k];
  end

  for (genvar g = 0; g < TG_COUNT; g++) begin : g_flat
    assign tg_o[g*REG_W +: REG_W] = tg_q[g];
  end

  assign ctrl0_o = ctrl0_q;
  assign ctrl1_o = ctrl1_q;
  assign ctrl2_o = ctrl2_q;

  // R2
  ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctrl0_q, ctrl1_q, ctrl2_q}) |-> $past(we_i));

  // R2
  tg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tg_o) |-> $past(we_i));

  // R5
  ctrl_foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i > A_CTRL2) |=> $stable({ctrl0_q, ctrl1_q, ctrl2_q}));

  logic [TG_W-1:0] unused_tg_w;
  assign unused_tg_w = '0;

endmodule

// File: rtl/vdec_ctl_decode.sv
module vdec_ctl_decode
  import vdec_ctl_pkg::*;
#(
  parameter int TG_COUNT = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [REG_W-1:0]          ctrl0_i,
  input  logic [REG_W-1:0]          ctrl1_i,
  input  logic [REG_W-1:0]          ctrl2_i,
  input  logic [TG_COUNT*REG_W-1:0] tg_i,
  input  logic                      line625_i,
  output logic                      tg_auto_o,
  output logic [4:0]                std_code_o,
  output comb_mode_e                comb_mode_o,
  output logic                      frame_comb_off_o,
  output logic                      comb_view_o,
  output logic                      blk_auto_en_o,
  output logic                      vbi_demod_en_o,
  output logic                      demod_bypass_o,
  output logic                      src_bypass_o,
  output logic [1:0]                osc_ctl_sel_o,
  output logic [TG_COUNT*REG_W-1:0] eff_tg_o
);

  logic [4:0]       std_next;
  logic [REG_W-1:0] tg_def_base;

  assign std_next    = resolve_std(ctrl0_i, line625_i);
  assign tg_def_base = std_next[2] ? TG_DEF_625 : TG_DEF_525;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tg_auto_o        <= D_CTRL0[7];
      std_code_o       <= resolve_std(D_CTRL0, 1'b0);
      comb_mode_o      <= decode_comb(D_CTRL1[2:0]);
      frame_comb_off_o <= D_CTRL1[5];
      comb_view_o      <= D_CTRL1[7];
      blk_auto_en_o    <= D_CTRL2[5];
      vbi_demod_en_o   <= D_CTRL2[4];
      demod_bypass_o   <= D_CTRL2[3];
      src_bypass_o     <= D_CTRL2[2];
      osc_ctl_sel_o    <= D_CTRL2[1:0];
    end else begin
      tg_auto_o        <= ctrl0_i[7];
      std_code_o       <= std_next;
      comb_mode_o      <= decode_comb(ctrl1_i[2:0]);
      frame_comb_off_o <= ctrl1_i[5];
      comb_view_o      <= ctrl1_i[7];
      blk_auto_en_o    <= ctrl2_i[5];
      vbi_demod_en_o   <= ctrl2_i[4];
      demod_bypass_o   <= ctrl2_i[3];
      src_bypass_o     <= ctrl2_i[2];
      osc_ctl_sel_o    <= ctrl2_i[1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < TG_COUNT; k++) begin
      if (!rst_n)
        eff_tg_o[k*REG_W +: REG_W] <= TG_DEF_525 + REG_W'(k);
      else if (ctrl0_i[7])
        eff_tg_o[k*REG_W +: REG_W] <= tg_def_base + REG_W'(k);
      else
        eff_tg_o[k*REG_W +: REG_W] <= tg_i[k*REG_W +: REG_W];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{ctrl0_i[6], ctrl1_i[6], ctrl1_i[4:3], ctrl2_i[7:6]};

  // R10
  eff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_auto_o && $past(tg_auto_o) && $stable(std_code_o)) |-> $stable(eff_tg_o));

endmodule

// File: rtl/vdec_ctl_regbank.sv
module vdec_ctl_regbank
  import vdec_ctl_pkg::*;
#(
  parameter int         TG_COUNT    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] VERSION     = 8'h07
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic                  line625_in,
  output logic [7:0]            rdata,
  output logic                  tg_auto,
  output logic [4:0]            std_code,
  output logic [1:0]            comb_mode,
  output logic                  frame_comb_off,
  output logic                  comb_view,
  output logic                  blk_auto_en,
  output logic                  vbi_demod_en,
  output logic                  demod_bypass,
  output logic                  src_bypass,
  output logic [1:0]            osc_ctl_sel,
  output logic [8*TG_COUNT-1:0] eff_tg
);

  localparam int TG_W = TG_COUNT * REG_W;

  logic             we;
  logic [REG_W-1:0] ctrl0, ctrl1, ctrl2;
  logic [TG_W-1:0]  tg_flat;
  comb_mode_e       comb_mode_e_w;

  vdec_ctl_wr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .wr_n  (wr_n),
    .we_o  (we)
  );

  vdec_ctl_store #(.TG_COUNT(TG_COUNT), .VERSION(VERSION)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .line625_i (line625_in),
    .rdata_o   (rdata),
    .ctrl0_o   (ctrl0),
    .ctrl1_o   (ctrl1),
    .ctrl2_o   (ctrl2),
    .tg_o      (tg_flat)
  );

  vdec_ctl_decode #(.TG_COUNT(TG_COUNT)) u_dec (
    .clk              (clk),
    .rst_n            (rst_n),
    .ctrl0_i          (ctrl0),
    .ctrl1_i          (ctrl1),
    .ctrl2_i          (ctrl2),
    .tg_i             (tg_flat),
    .line625_i        (line625_in),
    .tg_auto_o        (tg_auto),
    .std_code_o       (std_code),
    .comb_mode_o      (comb_mode_e_w),
    .frame_comb_off_o (frame_comb_off),
    .comb_view_o      (comb_view),
    .blk_auto_en_o    (blk_auto_en),
    .vbi_demod_en_o   (vbi_demod_en),
    .demod_bypass_o   (demod_bypass),
    .src_bypass_o     (src_bypass),
    .osc_ctl_sel_o    (osc_ctl_sel),
    .eff_tg_o         (eff_tg)
  );

  assign comb_mode = comb_mode_e_w;

endmodule

// File: tb/tb_vdec_ctl_regbank.sv
module tb_vdec_ctl_regbank;

  localparam int NTG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic cs_n = 1'b1, wr_n = 1'b1, line625_in = 1'b0;
  logic [7:0] rdata;
  logic tg_auto, frame_comb_off, comb_view, blk_auto_en, vbi_demod_en;
  logic demod_bypass, src_bypass;
  logic [4:0] std_code;
  logic [1:0] comb_mode, osc_ctl_sel;
  logic [8*NTG-1:0] eff_tg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] c0, c1, c2;
  logic [7:0] tgm [NTG];

  always #2 clk = ~clk;

  vdec_ctl_regbank dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .cs_n(cs_n),
    .wr_n(wr_n), .line625_in(line625_in), .rdata(rdata), .tg_auto(tg_auto),
    .std_code(std_code), .comb_mode(comb_mode), .frame_comb_off(frame_comb_off),
    .comb_view(comb_view), .blk_auto_en(blk_auto_en), .vbi_demod_en(vbi_demod_en),
    .demod_bypass(demod_bypass), .src_bypass(src_bypass),
    .osc_ctl_sel(osc_ctl_sel), .eff_tg(eff_tg)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(input logic [7:0] a);
    if (a == 8'h00) return 8'hBF;
    if (a == 8'h01) return 8'hA7;
    if (a == 8'h02) return 8'h3F;
    if (a >= 8'h10 && a < 8'h10 + NTG) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return c0;
    if (a == 8'h01) return c1;
    if (a == 8'h02) return c2;
    if (a == 8'h20) return {6'b0, line625_in, 1'b0};
    if (a == 8'h21) return 8'h07;
    if (a >= 8'h10 && a < 8'h10 + NTG) return tgm[a - 8'h10];
    return 8'h00;
  endfunction

  function automatic logic [4:0] exp_std();
    if (!c0[5]) return c0[4:0];
    return {2'b00, line625_in, c0[1], 1'b0};
  endfunction

  function automatic logic [1:0] exp_comb();
    if (c1[2]) return 2'd3;
    if (c1[1:0] == 2'b01) return 2'd1;
    if (c1[1:0] == 2'b10) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [7:0] exp_tg(input int k);
    logic [4:0] s;
    s = exp_std();
    if (c0[7]) return (s[2] ? 8'h80 : 8'h40) + 8'(k);
    return tgm[k];
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) c0 = d & 8'hBF;
    else if (a == 8'h01) c1 = d & 8'hA7;
    else if (a == 8'h02) c2 = d & 8'h3F;
    else if (wmask(a) != 0) tgm[a - 8'h10] = d;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    model_write(a, d);
  endtask

  task automatic check_reads(input string r);
    for (int a = 0; a < 48; a++) begin
      addr = 8'(a);
      #0.5;
      chk(r, rdata, exp_read(8'(a)));
    end
  endtask

  task automatic check_one(input string r, input logic [7:0] a);
    addr = a;
    #0.5;
    chk(r, rdata, exp_read(a));
  endtask

  task automatic check_dec(input string r);
    chk({r, " std"}, std_code, exp_std());
    chk({r, " comb"}, comb_mode, exp_comb());
    chk({r, " view/off"}, {comb_view, frame_comb_off}, {c1[7], c1[5]});
    chk({r, " ctrl2"}, {blk_auto_en, vbi_demod_en, demod_bypass, src_bypass, osc_ctl_sel},
        c2[5:0]);
    chk({r, " tgauto"}, tg_auto, c0[7]);
    for (int k = 0; k < NTG; k++)
      chk({r, " eff"}, eff_tg[k*8 +: 8], exp_tg(k));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, rd;
    void'($urandom(32'd7351));
    c0 = 8'hA0; c1 = 8'h04; c2 = 8'h24;
    for (int k = 0; k < NTG; k++) tgm[k] = 8'h40 + 8'(k);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset defaults, R5 unused zero, R6 status/version
    check_reads("R1");
    check_dec("R1");

    // R2 commit latency: visible only after edge N+3
    @(negedge clk);
    addr = 8'h01; wdata = 8'h81; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 before commit", rdata, 8'h04);
    @(negedge clk);
    chk("R2 after commit", rdata, 8'h81);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    model_write(8'h01, 8'h81);

    // R3 long strobe, data changed after commit
    @(negedge clk);
    addr = 8'h02; wdata = 8'h15; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wdata = 8'h2A;
    repeat (8) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
    model_write(8'h02, 8'h15);
    check_one("R3", 8'h02);

    // R4 only one enable low; R5 reads with enables in either state
    @(negedge clk);
    addr = 8'h00; wdata = 8'h00; cs_n = 1'b0; wr_n = 1'b1;
    repeat (6) @(negedge clk);
    check_reads("R5 cs low");
    cs_n = 1'b1; wr_n = 1'b0; addr = 8'h00;
    repeat (6) @(negedge clk);
    check_reads("R5 wr low");
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    check_one("R4", 8'h00);

    // R5 unused addresses and bits, R6 read-only
    bus_write(8'h05, 8'hFF);
    bus_write(8'h2F, 8'hFF);
    bus_write(8'h20, 8'hFF);
    bus_write(8'h21, 8'h00);
    bus_write(8'h01, 8'hFF);
    check_reads("R5 R6");
    line625_in = 1'b1;
    @(negedge clk);
    check_one("R6 status", 8'h20);

    // R7 auto standard combinations and manual
    repeat (2) @(negedge clk);
    check_dec("R7 auto 625");
    bus_write(8'h00, 8'hA2);
    check_dec("R7 auto 625 alt");
    line625_in = 1'b0;
    repeat (2) @(negedge clk);
    check_dec("R7 auto 525 alt");
    bus_write(8'h00, 8'h0C);
    check_dec("R7 manual");

    // R8 every comb code
    for (int m = 0; m < 8; m++) begin
      bus_write(8'h01, 8'(m) | (m[0] ? 8'h80 : 8'h20));
      check_dec("R8");
    end

    // R9 ctrl2 fields
    bus_write(8'h02, 8'h1B);
    check_dec("R9");
    bus_write(8'h02, 8'h26);
    check_dec("R9");

    // R10 override on/off, readback of programmed values
    bus_write(8'h13, 8'h5A);
    bus_write(8'h1F, 8'hC3);
    check_dec("R10 programmed");
    bus_write(8'h00, 8'hA0);
    line625_in = 1'b1;
    repeat (2) @(negedge clk);
    check_dec("R10 auto 625");
    check_one("R10 readback", 8'h13);
    line625_in = 1'b0;
    repeat (2) @(negedge clk);
    check_dec("R10 auto 525");

    // Random traffic
    for (int i = 0; i < 80; i++) begin
      ra = 8'($urandom % 48);
      if (($urandom % 4) == 0) ra = 8'($urandom % 3);
      rd = 8'($urandom);
      if (($urandom % 5) == 0) line625_in = ~line625_in;
      bus_write(ra, rd);
      check_one("R5 random", ra);
      check_dec("R10 random");
    end
    check_reads("R1 final sweep");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule